// File: doc/BRIEF.md
# Power-State Wakeup Event Controller

This block decides when a serial-port function that the host has put to sleep may ask the system to wake it. The host writes the power state and the wake-enable bit. The block watches the modem-control lines, the serial data input and two general-purpose wake pins. When a source that is valid for the current state shows activity, it sets a sticky wake status. While that status and the enable are both set, it drives an active-low, open-drain style wake request.

The block also gates the function while it is asleep. In either low-power state it stops the UART clock, forces the interrupt output off and refuses I/O and memory BAR accesses. Configuration access is not touched by this block. If serial data starts to arrive in the shallower sleep state, the block turns the UART clock back on at once, so that the framing of that data is kept. The power state never changes on its own: only host writes move it.

Top module: `pm_wake_ctrl`

## Requirements
- R1: After reset the block is in this state: `pme_sts`=0, `pme_n`=1, `uart_clk_en`=1, `irq_gate`=1, `bar_en`=1, and all wake mask bits are 0.
- R2: `pme_sts` stays set until a cycle in which `ctl_wr`=1 and `ctl_wsts`=1. A write with `ctl_wsts`=0 has no effect. If a wake event occurs in the same cycle as a clearing write, the set wins.
- R3: `pme_n` is 0 exactly when `pme_sts`=1 and `pme_en`=1. No wake event sets `pme_sts` while `pme_en`=0.
- R4: In D3 (`pstate`=2'b11) the only UART-side wake source is a 1-to-0 transition of the ring line `modem_in[2]`. The other modem lines, the serial input and a 0-to-1 ring transition are ignored in D3, whatever the mask holds.
- R5: In D2 (`pstate`=2'b10), any transition on `modem_in[i]` wakes the function when mask bit i is 0. Any transition on `sin` wakes it when mask bit 4 is 0. A line whose mask bit is 1 is ignored. In D0 (2'b00 or 2'b01) the UART-side lines never wake.
- R6: A cycle with `mask_wr`=1 loads `mask_wdata` into the wake mask, where bit i=1 disables line i. Because the mask resets to all zeros, every line is a wake source after reset.
- R7: Wake pin j raises a wake event whenever its synchronized value equals `gp_level[j]`. This holds in every power state, D0 included.
- R8: When the host moves to D2 or D3, `uart_clk_en`, `irq_gate` and `bar_en` go to 0 after the next rising clock edge. When the host returns to D0, they go back to 1 after the next rising edge, and `pme_sts` keeps its value.
- R9: An unmasked `sin` transition in D2 sets `uart_clk_en` to 1 at the same edge as the wake status. It stays 1 until the state leaves D2/D3. A modem-line wake does not re-enable the clock.
- R10: Wake timing is fixed, with no filter delay. An input transition applied between edges is visible in `pme_sts` after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pstate | input | 2 | Host power state: 00/01 D0, 10 D2, 11 D3 |
| pme_en | input | 1 | Wake request enable from the control register |
| ctl_wr | input | 1 | Host write strobe to the control register |
| ctl_wsts | input | 1 | Value written to the wake status bit (1 clears) |
| mask_wr | input | 1 | Host write strobe to the wake mask |
| mask_wdata | input | 5 | New mask: bits 0..3 modem lines, bit 4 serial input |
| modem_in | input | 4 | Asynchronous modem lines; bit 2 is the ring line |
| sin | input | 1 | Asynchronous serial data input |
| gp_pin | input | 2 | Asynchronous general-purpose wake pins |
| gp_level | input | 2 | Trigger level for each wake pin |
| pme_sts | output | 1 | Sticky wake status |
| pme_n | output | 1 | Active-low wake request |
| uart_clk_en | output | 1 | UART clock enable |
| irq_gate | output | 1 | Interrupt enable gate (0 forces interrupts off) |
| bar_en | output | 1 | I/O and memory BAR access allowed |

## Verification
A wrong per-state source decision shows up as `pme_sts` rising, or failing to rise, exactly three edges after a line toggle. So a faulty synchronizer depth or edge polarity is seen within one toggle, through timing alone. A lost sticky bit, or a clear that also responds to a written 0, shows on `pme_sts` and `pme_n` at the edge after the write. A stale power-state register shows as `bar_en`, `irq_gate` or `uart_clk_en` lagging or leading by one cycle after a state change. The mask contents are never read out: they are observed only through which toggles wake the function.

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl #(
  parameter int MODEM_W  = 4,
  parameter int RING_IDX = 2,
  parameter int GP_W     = 2,
  localparam int LINE_W  = MODEM_W + 1,
  localparam int SYNC_W  = LINE_W + GP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         pstate,
  input  logic               pme_en,
  input  logic               ctl_wr,
  input  logic               ctl_wsts,
  input  logic               mask_wr,
  input  logic [LINE_W-1:0]  mask_wdata,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               sin,
  input  logic [GP_W-1:0]    gp_pin,
  input  logic [GP_W-1:0]    gp_level,
  output logic               pme_sts,
  output logic               pme_n,
  output logic               uart_clk_en,
  output logic               irq_gate,
  output logic               bar_en
);
  logic [SYNC_W-1:0] sy1, sy2, prv;
  logic [LINE_W-1:0] mask_q;
  logic              low_q, clk_hold;

  wire [SYNC_W-1:0] raw = {gp_pin, sin, modem_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= raw;
      sy2 <= sy1;
      prv <= sy2;
    end

  wire in_d2 = (pstate == 2'b10);
  wire in_d3 = (pstate == 2'b11);
  wire asleep = in_d2 | in_d3;

  wire [LINE_W-1:0] line_chg = (sy2[LINE_W-1:0] ^ prv[LINE_W-1:0]) & ~mask_q;
  wire ring_fall = prv[RING_IDX] & ~sy2[RING_IDX];
  wire gp_hit    = |(~(sy2[SYNC_W-1:LINE_W] ^ gp_level));
  wire uart_wake = (in_d3 & ring_fall) | (in_d2 & (|line_chg));
  wire wake_evt  = pme_en & (uart_wake | gp_hit);
  wire sin_wake  = in_d2 & line_chg[MODEM_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pme_sts <= 1'b0;
    else if (wake_evt) pme_sts <= 1'b1;
    else if (ctl_wr && ctl_wsts) pme_sts <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      low_q    <= 1'b0;
      clk_hold <= 1'b0;
    end else begin
      low_q    <= asleep;
      clk_hold <= asleep & (clk_hold | sin_wake);
    end

  assign pme_n       = ~(pme_sts & pme_en);
  assign uart_clk_en = ~low_q | clk_hold;
  assign irq_gate    = ~low_q;
  assign bar_en      = ~low_q;
endmodule

module pm_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pstate,
  input logic       pme_en,
  input logic       ctl_wr,
  input logic       ctl_wsts,
  input logic       pme_sts,
  input logic       pme_n,
  input logic       uart_clk_en,
  input logic       irq_gate,
  input logic       bar_en
);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts && !(ctl_wr && ctl_wsts)) |=> pme_sts);

  a_r3_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!pme_en && !pme_sts) |=> !pme_sts);

  a_r3_pme_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_sts |-> pme_n);

  a_r8_d0_open: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate[1] == 1'b0) |=> (bar_en && irq_gate && uart_clk_en));

  a_r8_sleep_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate[1] == 1'b1) |=> (!bar_en && !irq_gate));

  a_r8_clk_follows_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bar_en |-> uart_clk_en);
endmodule

bind pm_wake_ctrl pm_wake_ctrl_chk chk_i (.*);

// File: tb/pm_wake_ctrl_tb.sv
module pm_wake_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pstate = 2'b00;
  logic pme_en = 1'b0, ctl_wr = 1'b0, ctl_wsts = 1'b0, mask_wr = 1'b0;
  logic [4:0] mask_wdata = '0;
  logic [3:0] modem_in = '0;
  logic sin = 1'b1;
  logic [1:0] gp_pin = 2'b00, gp_level = 2'b11;
  logic pme_sts, pme_n, uart_clk_en, irq_gate, bar_en;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pm_wake_ctrl dut_i (.*);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_sts();
    ctl_wr = 1; ctl_wsts = 1; tick(1); ctl_wr = 0; ctl_wsts = 0;
  endtask

  task automatic set_mask(input logic [4:0] m);
    mask_wr = 1; mask_wdata = m; tick(1); mask_wr = 0;
  endtask

  task automatic toggle(input int line);
    if (line == 4) sin = ~sin; else modem_in[line] = ~modem_in[line];
  endtask

  function automatic bit exp_wake(input logic [1:0] st, input logic [4:0] m,
                                  input int line, input bit oldv, input bit en);
    if (!en) return 0;
    if (st == 2'b11) return (line == 2) && oldv;
    if (st == 2'b10) return !m[line];
    return 0;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] m;
    tick(2); rst_n = 1; tick(3);
    // R1 reset state
    check("R1 sts", pme_sts, 0); check("R1 pme_n", pme_n, 1);
    check("R1 gates", {uart_clk_en, irq_gate, bar_en}, 3'b111);

    // R8 entry gating next edge
    pme_en = 1; pstate = 2'b10;
    check("R8 before edge", bar_en, 1);
    tick(1);
    check("R8 d2 gates", {uart_clk_en, irq_gate, bar_en}, 3'b000);

    // R6 reset mask enables cts; R10 timing
    toggle(0); tick(2);
    check("R10 not yet", pme_sts, 0);
    tick(1);
    check("R6 R10 wake", pme_sts, 1);
    check("R3 pme_n low", pme_n, 0);
    check("R9 modem no clk", uart_clk_en, 0);

    // R2 sticky
    ctl_wr = 1; ctl_wsts = 0; tick(1); ctl_wr = 0; tick(1);
    check("R2 write0", pme_sts, 1);
    pme_en = 0; tick(1);
    check("R3 pme_n disabled", pme_n, 1); check("R2 sts kept", pme_sts, 1);
    clear_sts(); tick(1);
    check("R2 cleared", pme_sts, 0);

    // R3 no set when disabled
    toggle(1); tick(4);
    check("R3 no set", pme_sts, 0);
    pme_en = 1; tick(3);
    check("R3 no late set", pme_sts, 0);

    // R9 sin wake reopens clock
    toggle(4); tick(2);
    check("R9 clk before", uart_clk_en, 0);
    tick(1);
    check("R9 clk on", uart_clk_en, 1); check("R9 sts", pme_sts, 1);
    check("R9 bar still off", bar_en, 0);
    clear_sts(); tick(2);
    check("R9 held", uart_clk_en, 1);

    // R5 masked line ignored
    set_mask(5'b00001); toggle(0); tick(4);
    check("R5 masked", pme_sts, 0);
    toggle(3); tick(3);
    check("R5 unmasked dcd", pme_sts, 1);
    clear_sts();

    // R4 D3
    pstate = 2'b11; tick(2);
    check("R9 hold dropped? d3 keeps asleep", irq_gate, 0);
    toggle(1); tick(4); check("R4 dsr ignored", pme_sts, 0);
    toggle(4); tick(4); check("R4 sin ignored", pme_sts, 0);
    toggle(2); tick(4); check("R4 ring rise ignored", pme_sts, 0);
    toggle(2); tick(3); check("R4 ring fall", pme_sts, 1);

    // R8 return to D0
    pstate = 2'b00; tick(1);
    check("R8 d0 gates", {uart_clk_en, irq_gate, bar_en}, 3'b111);
    check("R8 sts kept", pme_sts, 1);
    clear_sts(); tick(1);

    // R5 D0 no uart wake
    set_mask(5'b00000);
    toggle(0); tick(4); check("R5 d0 none", pme_sts, 0);

    // R7 gp pins in D0 and D3
    gp_pin[1] = 1; tick(2); check("R7 not yet", pme_sts, 0);
    tick(1); check("R7 d0 gp", pme_sts, 1);
    gp_pin[1] = 0; tick(3); clear_sts(); tick(1);
    check("R7 cleared", pme_sts, 0);
    pstate = 2'b11; gp_level = 2'b10; tick(3);
    check("R7 d3 gp", pme_sts, 1);
    gp_level = 2'b11; tick(1); clear_sts(); tick(1);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 60; i++) begin
      int line;
      bit oldv, en, e;
      logic [1:0] st;
      case ($urandom % 3) 0: st = 2'b00; 1: st = 2'b10; default: st = 2'b11; endcase
      m = 5'($urandom);
      en = ($urandom % 4) != 0;
      line = int'($urandom % 5);
      pstate = st; pme_en = en; set_mask(m); clear_sts(); tick(1);
      oldv = (line == 4) ? sin : modem_in[line];
      e = exp_wake(st, m, line, oldv, en);
      toggle(line); tick(3);
      check($sformatf("R4 R5 random st=%0d line=%0d", st, line), pme_sts, e);
      tick(1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule